// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a segment choice plus an offset to a linear address. It keeps six segment registers. Each register holds the selector that software loaded and a cached copy of the segment's base, limit, privilege level and validity. In real mode a load takes the selector value as a paragraph number: the base is that value times 16, the limit is 64 KB, and no table is read. In protected mode a load reads a descriptor from the global or the local table through a request/response port. The unit checks the descriptor's privilege against the current privilege level (CPL) and, if the check passes, fills the cache.

Each access picks a segment: CS for code fetches, DS for data, or any register named by the per-access override. The unit checks the last byte of the access against the cached limit and adds the cached base. Translation reads only the cached copy. A descriptor changed in memory after a load has no effect until that register is loaded again.

Segment codes used on `ld_seg` and `acc_ovr_seg`: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. Codes 6 and 7 name no register.

Top module: `seg_xlate`

## Requirements
- R1: In real mode (`pmode`=0), loading a selector S sets that register's base to S*16 and its limit to 0xFFFF in one cycle, with no table request. Its translation is (base + offset) truncated to 20 bits, with bits 31:20 of `lin_addr` zero.
- R2: `acc_size` is the access length in bytes minus one. An access whose last byte (offset + `acc_size`) lies past the cached limit raises `acc_fault`. In real mode this means any byte above 0xFFFF.
- R3: In protected mode, a load of a non-null selector asserts `busy` and drives `dreq_valid` with `dreq_addr` = (selector bit 2 = 0 ? global base : local base) + (selector with bits 2:0 cleared). Address and valid stay stable until `dreq_ready`.
- R4: A protected load succeeds only if the returned privilege level is numerically >= CPL. Otherwise `ld_done` comes with `ld_fault` and the register keeps its previous contents. Selector bits 1:0 play no part in any check.
- R5: A successful protected load of CS sets `cpl` to the descriptor's privilege level. CPL changes at no other time, and it is 0 after reset.
- R6: In protected mode the linear address is the cached base plus the offset, over the full 32 bits. On any fault `lin_addr` is 0. Results appear on `acc_rdy` one cycle after `acc_valid`.
- R7: Translation uses only the cached copy. A changed descriptor in the table takes effect only after the register is reloaded.
- R8: Code fetches (`acc_code`=1) use CS, and data accesses use DS. With `acc_ovr_en` set, `acc_ovr_seg` names the register for that access only. Codes 6 and 7 fault.
- R9: A null selector (bits 15:2 zero) loaded into ES, DS, FS or GS in protected mode completes without a fault or table request and marks the register invalid, so accesses through it fault. A null load into CS or SS faults and changes nothing.
- R10: A write to a table base (`tbl_sel` 0 global, 1 local) takes effect only when CPL is 0.
- R11: After reset CPL is 0, `busy` and `dreq_valid` are low, and every register is valid with base 0 and limit 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pmode | input | 1 | 1 = protected mode, 0 = real mode |
| tbl_we | input | 1 | Table base write strobe |
| tbl_sel | input | 1 | 0 global table base, 1 local table base |
| tbl_wdata | input | 32 | New table base |
| ld_valid | input | 1 | Selector load request (taken when not busy) |
| ld_seg | input | 3 | Segment register to load |
| ld_sel | input | 16 | Selector value |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_fault | output | 1 | Load faulted, valid with ld_done |
| cpl | output | 2 | Current privilege level |
| dreq_valid | output | 1 | Descriptor read request |
| dreq_ready | input | 1 | Request accepted |
| dreq_addr | output | 32 | Descriptor address |
| dresp_valid | input | 1 | Descriptor response strobe |
| dresp_base | input | 32 | Descriptor base |
| dresp_limit | input | 20 | Descriptor limit (byte units) |
| dresp_dpl | input | 2 | Descriptor privilege level |
| acc_valid | input | 1 | Access request |
| acc_code | input | 1 | Access is a code fetch |
| acc_ovr_en | input | 1 | Use override segment |
| acc_ovr_seg | input | 3 | Override segment code |
| acc_off | input | 32 | Offset |
| acc_size | input | 2 | Bytes minus one |
| acc_rdy | output | 1 | Access result valid |
| acc_fault | output | 1 | Access faulted |
| lin_addr | output | 32 | Linear address, 0 on fault |

## Verification
The hardest case to reach is a cache that is stale on purpose. The bench must load a register, change the descriptor the table would return, and show that translations still use the old base until the register is reloaded. The bench's responder builds each descriptor from its address plus a version number that the stimulus can bump. This lets one selector return different bases before and after a reload. Privilege faults need CPL above zero, so the sequence first far-loads CS with a privilege-3 descriptor, then tries loads and table base writes at that level.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 6,
  parameter int LIMW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pmode,
  input  logic            tbl_we,
  input  logic            tbl_sel,
  input  logic [31:0]     tbl_wdata,
  input  logic            ld_valid,
  input  logic [2:0]      ld_seg,
  input  logic [15:0]     ld_sel,
  output logic            busy,
  output logic            ld_done,
  output logic            ld_fault,
  output logic [1:0]      cpl,
  output logic            dreq_valid,
  input  logic            dreq_ready,
  output logic [31:0]     dreq_addr,
  input  logic            dresp_valid,
  input  logic [31:0]     dresp_base,
  input  logic [LIMW-1:0] dresp_limit,
  input  logic [1:0]      dresp_dpl,
  input  logic            acc_valid,
  input  logic            acc_code,
  input  logic            acc_ovr_en,
  input  logic [2:0]      acc_ovr_seg,
  input  logic [31:0]     acc_off,
  input  logic [1:0]      acc_size,
  output logic            acc_rdy,
  output logic            acc_fault,
  output logic [31:0]     lin_addr
);
  localparam logic [2:0] SEG_CS = 3'd1;
  localparam logic [2:0] SEG_SS = 3'd2;
  localparam logic [2:0] SEG_DS = 3'd3;
  localparam logic [2:0] NSEG_C = 3'(NSEG);
  localparam int SLOTS = 8;
  localparam logic [LIMW-1:0] REAL_LIM = LIMW'(20'h0FFFF);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [31:0]     gdt_base, ldt_base;
  logic [2:0]      pend_seg;
  logic [15:0]     seg_sel  [SLOTS];
  logic [31:0]     seg_base [SLOTS];
  logic [LIMW-1:0] seg_lim  [SLOTS];
  logic [1:0]      seg_dpl  [SLOTS];
  logic            seg_ok   [SLOTS];

  wire ld_go    = ld_valid && (st == S_IDLE);
  wire ld_bad   = ld_seg >= NSEG_C;
  wire ld_null  = (ld_sel[15:2] == 14'd0);
  wire ld_data  = (ld_seg != SEG_CS) && (ld_seg != SEG_SS);
  wire priv_ok  = dresp_dpl >= cpl;

  assign busy       = (st != S_IDLE);
  assign dreq_valid = (st == S_REQ);

  logic [2:0]  a_seg;
  logic [32:0] a_end;
  logic [31:0] a_sum;
  logic        a_flt;

  assign a_seg = acc_ovr_en ? acc_ovr_seg : (acc_code ? SEG_CS : SEG_DS);
  assign a_end = {1'b0, acc_off} + {31'b0, acc_size};
  assign a_sum = seg_base[a_seg] + acc_off;
  assign a_flt = (a_seg >= NSEG_C) || !seg_ok[a_seg] ||
                 (a_end > {{(33-LIMW){1'b0}}, seg_lim[a_seg]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cpl       <= 2'd0;
      gdt_base  <= '0;
      ldt_base  <= '0;
      pend_seg  <= '0;
      dreq_addr <= '0;
      ld_done   <= 1'b0;
      ld_fault  <= 1'b0;
      acc_rdy   <= 1'b0;
      acc_fault <= 1'b0;
      lin_addr  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        seg_sel[i]  <= '0;
        seg_base[i] <= '0;
        seg_lim[i]  <= REAL_LIM;
        seg_dpl[i]  <= '0;
        seg_ok[i]   <= 1'b1;
      end
    end else begin
      ld_done  <= 1'b0;
      ld_fault <= 1'b0;

      if (tbl_we && cpl == 2'd0) begin
        if (tbl_sel) ldt_base <= tbl_wdata;
        else         gdt_base <= tbl_wdata;
      end

      case (st)
        S_IDLE: if (ld_go) begin
          if (ld_bad) begin
            ld_done  <= 1'b1;
            ld_fault <= 1'b1;
          end else if (!pmode) begin
            seg_sel[ld_seg]  <= ld_sel;
            seg_base[ld_seg] <= {12'd0, ld_sel, 4'd0};
            seg_lim[ld_seg]  <= REAL_LIM;
            seg_dpl[ld_seg]  <= 2'd0;
            seg_ok[ld_seg]   <= 1'b1;
            ld_done          <= 1'b1;
          end else if (ld_null) begin
            ld_done <= 1'b1;
            if (ld_data) begin
              seg_sel[ld_seg] <= ld_sel;
              seg_ok[ld_seg]  <= 1'b0;
            end else begin
              ld_fault <= 1'b1;
            end
          end else begin
            st       <= S_REQ;
            pend_seg <= ld_seg;
            seg_sel[SLOTS-1] <= ld_sel;
            dreq_addr <= (ld_sel[2] ? ldt_base : gdt_base) +
                         {16'd0, ld_sel[15:3], 3'd0};
          end
        end
        S_REQ: if (dreq_ready) st <= S_WAIT;
        S_WAIT: if (dresp_valid) begin
          st       <= S_IDLE;
          ld_done  <= 1'b1;
          ld_fault <= !priv_ok;
          if (priv_ok) begin
            seg_sel[pend_seg]  <= seg_sel[SLOTS-1];
            seg_base[pend_seg] <= dresp_base;
            seg_lim[pend_seg]  <= dresp_limit;
            seg_dpl[pend_seg]  <= dresp_dpl;
            seg_ok[pend_seg]   <= 1'b1;
            if (pend_seg == SEG_CS) cpl <= dresp_dpl;
          end
        end
        default: st <= S_IDLE;
      endcase

      acc_rdy   <= acc_valid;
      acc_fault <= acc_valid && a_flt;
      if (acc_valid && !a_flt)
        lin_addr <= pmode ? a_sum : {12'd0, a_sum[19:0]};
      else
        lin_addr <= '0;
    end
  end
endmodule

module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pmode,
  input logic        tbl_we,
  input logic [1:0]  cpl,
  input logic [31:0] gdt_base,
  input logic [31:0] ldt_base,
  input logic        dreq_valid,
  input logic        dreq_ready,
  input logic [31:0] dreq_addr,
  input logic        ld_done,
  input logic        ld_fault,
  input logic        acc_rdy,
  input logic        acc_fault,
  input logic [31:0] lin_addr
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_addr));

  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdy && acc_fault |-> lin_addr == 32'd0);

  a_r5_cpl_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpl) |-> ld_done && !ld_fault);

  a_r10_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we && cpl != 2'd0 |=> $stable(gdt_base) && $stable(ldt_base));

  a_r1_real_width: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdy && !$past(pmode) |-> lin_addr[31:20] == 12'd0);
endmodule

bind seg_xlate seg_xlate_chk chk (
  .clk(clk), .rst_n(rst_n), .pmode(pmode), .tbl_we(tbl_we), .cpl(cpl),
  .gdt_base(gdt_base), .ldt_base(ldt_base), .dreq_valid(dreq_valid),
  .dreq_ready(dreq_ready), .dreq_addr(dreq_addr), .ld_done(ld_done),
  .ld_fault(ld_fault), .acc_rdy(acc_rdy), .acc_fault(acc_fault),
  .lin_addr(lin_addr)
);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  logic        clk = 0, rst_n = 0, pmode = 0;
  logic        tbl_we = 0, tbl_sel = 0;
  logic [31:0] tbl_wdata = 0;
  logic        ld_valid = 0;
  logic [2:0]  ld_seg = 0;
  logic [15:0] ld_sel = 0;
  logic        busy, ld_done, ld_fault, dreq_valid;
  logic [1:0]  cpl;
  logic [31:0] dreq_addr;
  logic        dreq_ready = 0, dresp_valid = 0;
  logic [31:0] dresp_base = 0;
  logic [19:0] dresp_limit = 0;
  logic [1:0]  dresp_dpl = 0;
  logic        acc_valid = 0, acc_code = 0, acc_ovr_en = 0;
  logic [2:0]  acc_ovr_seg = 0;
  logic [31:0] acc_off = 0;
  logic [1:0]  acc_size = 0;
  logic        acc_rdy, acc_fault;
  logic [31:0] lin_addr;

  int tests = 0, fails = 0;
  int ver = 0, hold = 0;
  logic        rsp_pend = 0;
  logic [31:0] rsp_addr = 0, last_addr = 0;
  logic        saw_busy, got_fault, got_acc_fault;
  logic [31:0] got_lin;

  always #4 clk = ~clk;

  seg_xlate uut (.*);

  always @(negedge clk) begin
    dreq_ready  = 0;
    dresp_valid = 0;
    if (rsp_pend) begin
      dresp_valid = 1;
      dresp_base  = {8'd0, rsp_addr[15:0], 8'd0} + (32'(ver) << 20);
      dresp_limit = 20'h00FFF;
      dresp_dpl   = rsp_addr[4:3];
      rsp_pend    = 0;
    end else if (dreq_valid) begin
      if (hold == 2) begin
        dreq_ready = 1;
        rsp_addr   = dreq_addr;
        last_addr  = dreq_addr;
        rsp_pend   = 1;
        hold       = 0;
      end else hold++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] seg, input logic [15:0] sel);
    int n = 0;
    @(negedge clk);
    ld_valid = 1; ld_seg = seg; ld_sel = sel;
    @(negedge clk);
    ld_valid = 0;
    saw_busy = 0;
    while (!ld_done && n < 50) begin
      if (busy) saw_busy = 1;
      @(negedge clk);
      n++;
    end
    got_fault = ld_fault;
  endtask

  task automatic do_acc(input logic code, input logic ovr, input logic [2:0] oseg,
                        input logic [31:0] off, input logic [1:0] sz);
    @(negedge clk);
    acc_valid = 1; acc_code = code; acc_ovr_en = ovr; acc_ovr_seg = oseg;
    acc_off = off; acc_size = sz;
    @(negedge clk);
    acc_valid = 0; acc_ovr_en = 0; acc_code = 0;
    got_lin = lin_addr;
    got_acc_fault = acc_fault;
  endtask

  task automatic wr_tbl(input logic which, input logic [31:0] v);
    @(negedge clk);
    tbl_we = 1; tbl_sel = which; tbl_wdata = v;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // sel, offset, size, expected linear, expected fault
  localparam logic [82:0] VEC [6] = '{
    {16'h1004, 32'h0000_1000, 2'd3, 32'h0001_1040, 1'b0},
    {16'hFFFF, 32'h0000_FFFF, 2'd0, 32'h0000_FFEF, 1'b0},
    {16'h1234, 32'h0000_FFFD, 2'd1, 32'h0002_233D, 1'b0},
    {16'h1234, 32'h0000_FFFD, 2'd3, 32'h0000_0000, 1'b1},
    {16'h0000, 32'h0001_0000, 2'd0, 32'h0000_0000, 1'b1},
    {16'hABCD, 32'h0000_0000, 2'd2, 32'h000A_BCD0, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 cpl", 32'(cpl), 0);
    check("R11 busy", 32'(busy), 0);
    check("R11 dreq_valid", 32'(dreq_valid), 0);
    do_acc(0, 0, 0, 32'h1234, 0);
    check("R11 DS reset base", got_lin, 32'h1234);

    for (int i = 0; i < 6; i++) begin
      do_load(3'd3, VEC[i][82:67]);
      check("R1 real load fault", 32'(got_fault), 0);
      check("R1 real load no fetch", 32'(saw_busy), 0);
      do_acc(0, 0, 0, VEC[i][66:35], VEC[i][34:33]);
      check("R1/R2 real linear", got_lin, VEC[i][32:1]);
      check("R2 real fault", 32'(got_acc_fault), 32'(VEC[i][0]));
    end

    pmode = 1;
    wr_tbl(0, 32'h0001_0000);
    wr_tbl(1, 32'h0002_0000);

    do_load(3'd3, 16'h0013);
    check("R3 global addr", last_addr, 32'h0001_0010);
    check("R3 busy seen", 32'(saw_busy), 1);
    check("R4 rpl ignored load ok", 32'(got_fault), 0);
    do_acc(0, 0, 0, 32'h10, 3);
    check("R6 prot linear", got_lin, 32'h1010);
    do_acc(0, 0, 0, 32'hFFC, 3);
    check("R6 last byte at limit", got_lin, 32'h1FFC);
    do_acc(0, 0, 0, 32'hFFD, 3);
    check("R6 past limit fault", 32'(got_acc_fault), 1);
    check("R6 fault lin zero", got_lin, 0);

    ver = 1;
    do_acc(0, 0, 0, 32'h10, 0);
    check("R7 stale cache kept", got_lin, 32'h1010);
    do_load(3'd3, 16'h0013);
    do_acc(0, 0, 0, 32'h10, 0);
    check("R7 reload picks new", got_lin, 32'h0010_1010);

    do_load(3'd0, 16'h000C);
    check("R3 local addr", last_addr, 32'h0002_0008);
    do_acc(0, 1, 3'd0, 32'h4, 0);
    check("R8 override ES", got_lin, 32'h0010_0804);
    do_acc(0, 0, 0, 32'h4, 0);
    check("R8 default DS", got_lin, 32'h0010_1004);
    do_acc(1, 0, 0, 32'h20, 0);
    check("R8 code uses CS", got_lin, 32'h20);
    do_acc(0, 1, 3'd6, 32'h0, 0);
    check("R8 bad override fault", 32'(got_acc_fault), 1);

    do_load(3'd1, 16'h0018);
    check("R5 CS load ok", 32'(got_fault), 0);
    check("R5 cpl from CS", 32'(cpl), 3);
    do_acc(1, 0, 0, 32'h8, 0);
    check("R5 CS base", got_lin, 32'h0010_1808);

    wr_tbl(0, 32'h0003_0000);
    do_load(3'd4, 16'h0018);
    check("R10 write ignored at cpl3", last_addr, 32'h0001_0018);

    do_load(3'd5, 16'h0010);
    check("R4 priv fault", 32'(got_fault), 1);
    check("R5 cpl unchanged", 32'(cpl), 3);
    do_acc(0, 1, 3'd5, 32'h5, 0);
    check("R4 GS unchanged", got_lin, 32'h5);

    do_load(3'd3, 16'h0003);
    check("R9 null data ok", 32'(got_fault), 0);
    check("R9 null no fetch", 32'(saw_busy), 0);
    do_acc(0, 0, 0, 32'h0, 0);
    check("R9 invalid DS fault", 32'(got_acc_fault), 1);
    do_load(3'd2, 16'h0000);
    check("R9 null SS fault", 32'(got_fault), 1);
    do_acc(0, 1, 3'd2, 32'h7, 0);
    check("R9 SS unchanged", got_lin, 32'h7);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule